// File: doc/BRIEF.md
# Host-Slave Mailbox Attention Flags

This block holds the three attention flags of a message mailbox that sits between a host port and a slave port. One flag reports a slave event. One says the slave has filled the buffer for the host. One says the host has filled the buffer for the slave. Each flag has its own rules for which side may raise it and which side may drop it.

The slave side must first read the flag in the opposite state before its write takes effect. This read-before-write handshake stops the slave from acting on a stale view of a bit that the host may have changed. The two slave-raised flags, gated by an enable bit that the slave owns, drive a registered interrupt request to the host. Both ports see the same status byte through plain read and write strobes. The flags sit at fixed bit positions because the host-side software decodes them there.

Top module: `mbx_attn_flags`

## Requirements
- R1: After reset, every status bit reads 0, the interrupt enable reads 0 and `host_irq` is 0.
- R2: A host write with a 1 at bit 4 (slave event) or bit 3 (slave-to-host ready) clears that flag on the next clock edge. A host write with a 0 at that position leaves the flag unchanged.
- R3: A slave write with a 1 at bit 4 or bit 3 sets that flag, but only when the slave's most recent status read, since its last status write, saw that bit as 0. Without such a read, the write has no effect.
- R4: A host write with a 1 at bit 2 (host-to-slave ready) sets that flag. A host 0 at bit 2 has no effect, and a slave 1 at bit 2 has no effect.
- R5: A slave write with a 0 at bit 2 clears that flag, but only when the slave's most recent status read, since its last status write, saw bit 2 as 1.
- R6: Any slave status write consumes the arming from the preceding read for all three flags, even when the write changes nothing.
- R7: Status bits other than 4, 3 and 2 always read 0, and writes to them are ignored. Both ports read the same status value.
- R8: `host_irq` equals, one clock after the fact, the AND of the enable bit with the OR of the slave event flag and the slave-to-host ready flag.
- R9: A write on the enable port stores `ie_wdata`, and `ie_rdata` returns the stored value from the next edge on.
- R10: When a host action and an armed slave action target the same flag in the same cycle, the host action wins.
- R11: A slave read and a slave write in the same cycle: the write acts on the arming held before that cycle, and the read does not leave anything armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host status write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status as seen by the host |
| slv_rd | input | 1 | Slave status read strobe (arms flags) |
| slv_wr | input | 1 | Slave status write strobe |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Status as seen by the slave |
| ie_wr | input | 1 | Slave write strobe for the interrupt enable |
| ie_wdata | input | 1 | New interrupt enable value |
| ie_rdata | output | 1 | Stored interrupt enable |
| host_irq | output | 1 | Registered interrupt request to the host |

## Verification
Two kinds of collision are tested. In the first, a host write and an armed slave write land on the same flag in the same cycle. The bench arms the slave with a read, then drives both write strobes together. It expects the host's outcome: the event flag stays clear, and the host-to-slave flag stays set. In the second, a slave read and a slave write share a cycle. The bench checks that the write uses only the arming from before that cycle, and that a later lone write still has no effect.

// File: rtl/mbx_attn_pkg.sv
package mbx_attn_pkg;
   localparam int NUM_FLAGS = 3;
   typedef enum logic [1:0] {
      FLG_EVT = 2'd0,
      FLG_S2H = 2'd1,
      FLG_H2S = 2'd2
   } flag_id_e;
   typedef struct packed {
      logic evt;
      logic s2h;
      logic h2s;
   } flags_t;
endpackage

// File: rtl/mbx_attn_cell.sv
module mbx_attn_cell #(
   parameter bit SLV_SETS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_wr,
   input  logic host_bit,
   input  logic slv_rd,
   input  logic slv_wr,
   input  logic slv_bit,
   output logic flag_q
);
   localparam bit ARM_VAL  = ~SLV_SETS;
   localparam bit SLV_VAL  = SLV_SETS;
   localparam bit HOST_VAL = ~SLV_SETS;

   logic armed_q;
   logic host_act;
   logic slv_act;
   logic flag_d;

   assign host_act = host_wr & host_bit;
   assign slv_act  = slv_wr & armed_q & (slv_bit == SLV_VAL);

   always_comb begin
      flag_d = flag_q;
      if (slv_act)
         flag_d = SLV_VAL;
      if (host_act)
         flag_d = HOST_VAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         flag_q <= flag_d;
         if (slv_wr)
            armed_q <= 1'b0;
         else if (slv_rd)
            armed_q <= (flag_q == ARM_VAL);
      end
   end
endmodule

// File: rtl/mbx_attn_irq.sv
module mbx_attn_irq #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ie_wr,
   input  logic ie_wdata,
   input  logic src_evt,
   input  logic src_s2h,
   output logic ie_q,
   output logic irq
);
   logic req;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ie_q <= 1'b0;
      else if (ie_wr)
         ie_q <= ie_wdata;
   end

   assign req = ie_q & (src_evt | src_s2h);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= req;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = req;
      end
   endgenerate
endmodule

// File: rtl/mbx_attn_flags.sv
module mbx_attn_flags
   import mbx_attn_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter int EVT_POS = 4,
   parameter int S2H_POS = 3,
   parameter int H2S_POS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [STAT_W-1:0] host_wdata,
   output logic [STAT_W-1:0] host_rdata,
   input  logic              slv_rd,
   input  logic              slv_wr,
   input  logic [STAT_W-1:0] slv_wdata,
   output logic [STAT_W-1:0] slv_rdata,
   input  logic              ie_wr,
   input  logic              ie_wdata,
   output logic              ie_rdata,
   output logic              host_irq
);
   localparam int FLAG_POS [NUM_FLAGS] = '{EVT_POS, S2H_POS, H2S_POS};
   localparam bit SLV_SET  [NUM_FLAGS] = '{1'b1, 1'b1, 1'b0};

   generate
      if (EVT_POS >= STAT_W || S2H_POS >= STAT_W || H2S_POS >= STAT_W) begin : g_bad_pos
         $error("flag position outside status width");
      end
      if (EVT_POS == S2H_POS || EVT_POS == H2S_POS || S2H_POS == H2S_POS) begin : g_dup_pos
         $error("flag positions must differ");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] flag_vec;
   flags_t               flags;
   logic [STAT_W-1:0]    status;

   generate
      for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         mbx_attn_cell #(.SLV_SETS(SLV_SET[gi])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .host_wr  (host_wr),
            .host_bit (host_wdata[FLAG_POS[gi]]),
            .slv_rd   (slv_rd),
            .slv_wr   (slv_wr),
            .slv_bit  (slv_wdata[FLAG_POS[gi]]),
            .flag_q   (flag_vec[gi])
         );
      end
   endgenerate

   assign flags.evt = flag_vec[FLG_EVT];
   assign flags.s2h = flag_vec[FLG_S2H];
   assign flags.h2s = flag_vec[FLG_H2S];

   always_comb begin
      status          = '0;
      status[EVT_POS] = flags.evt;
      status[S2H_POS] = flags.s2h;
      status[H2S_POS] = flags.h2s;
   end

   assign host_rdata = status;
   assign slv_rdata  = status;

   mbx_attn_irq #(.REG_OUT(1'b1)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ie_wr    (ie_wr),
      .ie_wdata (ie_wdata),
      .src_evt  (flags.evt),
      .src_s2h  (flags.s2h),
      .ie_q     (ie_rdata),
      .irq      (host_irq)
   );
endmodule

// File: rtl/mbx_attn_chk.sv
module mbx_attn_chk #(
   parameter int STAT_W  = 8,
   parameter int EVT_POS = 4,
   parameter int S2H_POS = 3,
   parameter int H2S_POS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [STAT_W-1:0] host_wdata,
   input logic [STAT_W-1:0] host_rdata,
   input logic              slv_wr,
   input logic [STAT_W-1:0] slv_wdata,
   input logic [STAT_W-1:0] slv_rdata,
   input logic              ie_rdata,
   input logic              host_irq
);
   logic [STAT_W-1:0] flag_mask;
   always_comb begin
      flag_mask          = '0;
      flag_mask[EVT_POS] = 1'b1;
      flag_mask[S2H_POS] = 1'b1;
      flag_mask[H2S_POS] = 1'b1;
   end

   assert_host_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_wdata[EVT_POS] |=> !host_rdata[EVT_POS]);

   assert_evt_rise_by_slave_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdata[EVT_POS]) |-> $past(slv_wr && slv_wdata[EVT_POS]));

   assert_s2h_rise_by_slave_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdata[S2H_POS]) |-> $past(slv_wr && slv_wdata[S2H_POS]));

   assert_host_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_wdata[H2S_POS] |=> host_rdata[H2S_POS]);

   assert_h2s_fall_by_slave_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_rdata[H2S_POS]) |-> $past(slv_wr && !slv_wdata[H2S_POS] && !host_wr));

   assert_spare_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_rdata & ~flag_mask) == '0) && (host_rdata == slv_rdata));

   assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 host_irq == $past(ie_rdata && (host_rdata[EVT_POS] || host_rdata[S2H_POS])));
endmodule

bind mbx_attn_flags mbx_attn_chk #(
   .STAT_W(STAT_W), .EVT_POS(EVT_POS), .S2H_POS(S2H_POS), .H2S_POS(H2S_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .slv_wr     (slv_wr),
   .slv_wdata  (slv_wdata),
   .slv_rdata  (slv_rdata),
   .ie_rdata   (ie_rdata),
   .host_irq   (host_irq)
);

// File: tb/sim_mbx_attn_flags.sv
module sim_mbx_attn_flags;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       slv_rd = 1'b0;
   logic       slv_wr = 1'b0;
   logic [7:0] slv_wdata = '0;
   logic [7:0] slv_rdata;
   logic       ie_wr = 1'b0;
   logic       ie_wdata = 1'b0;
   logic       ie_rdata;
   logic       host_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_attn_flags u0 (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .slv_rd(slv_rd), .slv_wr(slv_wr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata),
      .ie_wr(ie_wr), .ie_wdata(ie_wdata), .ie_rdata(ie_rdata), .host_irq(host_irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // one clock of activity; entered and left at a falling edge
   task automatic step(input bit hw, input logic [7:0] hd, input bit sr,
                       input bit sw, input logic [7:0] sd);
      host_wr = hw; host_wdata = hd; slv_rd = sr; slv_wr = sw; slv_wdata = sd;
      @(negedge clk);
      host_wr = 0; slv_rd = 0; slv_wr = 0;
   endtask

   task automatic idle();
      step(0, 8'h00, 0, 0, 8'h00);
   endtask

   task automatic set_ie(input bit v);
      ie_wr = 1'b1; ie_wdata = v;
      @(negedge clk);
      ie_wr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 status", host_rdata, 8'h00);
      check("R1 irq", {7'd0, host_irq}, 8'h00);
      check("R1 ie", {7'd0, ie_rdata}, 8'h00);
   endtask

   task automatic t_event();
      step(0, 8'h00, 0, 1, 8'h10);
      check("R3 unarmed set ignored", host_rdata, 8'h00);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h10);
      check("R3 armed set", host_rdata, 8'h10);
      check("R8 irq off while disabled", {7'd0, host_irq}, 8'h00);
      set_ie(1'b1);
      check("R9 ie readback", {7'd0, ie_rdata}, 8'h01);
      check("R8 irq lags enable", {7'd0, host_irq}, 8'h00);
      idle();
      check("R8 irq raised", {7'd0, host_irq}, 8'h01);
      step(1, 8'h00, 0, 0, 8'h00);
      check("R2 host zero keeps flag", host_rdata, 8'h10);
      step(1, 8'h10, 0, 0, 8'h00);
      check("R2 host clear", host_rdata, 8'h00);
      check("R8 irq held one cycle", {7'd0, host_irq}, 8'h01);
      idle();
      check("R8 irq dropped", {7'd0, host_irq}, 8'h00);
   endtask

   task automatic t_arm_consumed();
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h00);
      step(0, 8'h00, 0, 1, 8'h08);
      check("R6 arm used by null write", host_rdata, 8'h00);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h08);
      check("R3 s2h set", slv_rdata, 8'h08);
      idle();
      check("R8 irq from s2h", {7'd0, host_irq}, 8'h01);
      step(1, 8'h08, 0, 0, 8'h00);
      check("R2 s2h clear", host_rdata, 8'h00);
      set_ie(1'b0);
      check("R9 ie cleared", {7'd0, ie_rdata}, 8'h00);
   endtask

   task automatic t_h2s();
      step(1, 8'h04, 0, 0, 8'h00);
      check("R4 host set", host_rdata, 8'h04);
      step(0, 8'h00, 0, 1, 8'h00);
      check("R5 unarmed clear ignored", host_rdata, 8'h04);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h04);
      check("R4 slave one no effect", host_rdata, 8'h04);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h00);
      check("R5 armed clear", host_rdata, 8'h00);
      step(1, 8'h00, 0, 0, 8'h00);
      check("R4 host zero no effect", host_rdata, 8'h00);
      step(0, 8'h00, 1, 0, 8'h00);
      step(1, 8'h04, 0, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h00);
      check("R5 read of zero does not arm", host_rdata, 8'h04);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h00);
      check("R5 cleanup clear", host_rdata, 8'h00);
   endtask

   task automatic t_spare_bits();
      step(1, 8'hE3, 0, 0, 8'h00);
      check("R7 host spare write", host_rdata, 8'h00);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'hE3);
      check("R7 slave spare write", slv_rdata, 8'h00);
      step(1, 8'h04, 0, 0, 8'h00);
      check("R7 ports agree", slv_rdata, host_rdata);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h00);
   endtask

   task automatic t_conflict();
      step(0, 8'h00, 1, 0, 8'h00);
      step(1, 8'h10, 0, 1, 8'h10);
      check("R10 host clear beats slave set", host_rdata, 8'h00);
      step(1, 8'h04, 0, 0, 8'h00);
      step(0, 8'h00, 1, 0, 8'h00);
      step(1, 8'h04, 0, 1, 8'h00);
      check("R10 host set beats slave clear", host_rdata, 8'h04);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 0, 1, 8'h00);
   endtask

   task automatic t_rd_wr_same();
      step(0, 8'h00, 1, 1, 8'h10);
      check("R11 same-cycle read does not arm write", host_rdata, 8'h00);
      step(0, 8'h00, 0, 1, 8'h10);
      check("R11 same-cycle read leaves nothing armed", host_rdata, 8'h00);
      step(0, 8'h00, 1, 0, 8'h00);
      step(0, 8'h00, 1, 1, 8'h10);
      check("R11 write uses prior arm", host_rdata, 8'h10);
      step(1, 8'h10, 0, 0, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_event();
      t_arm_consumed();
      t_h2s();
      t_spare_bits();
      t_conflict();
      t_rd_wr_same();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule